// File: doc/BRIEF.md
# Core Sleep State Sequencer

This block puts one processor core to sleep and wakes it again. When no work is ready, an idle request arrives with a 2-bit depth argument. The depth selects a light halt (C1), a deeper clock-stopped state (C3) or a power-gated state (C6). The block then applies the entry steps for that depth one at a time. It stalls the pipeline and gates most core clocks, but the snoop-path clock keeps running. For C3 it flushes the core caches and then gates the remaining clocks. For C6 it saves the architectural state and then opens the core power gate.

A deeper level always performs every step of the shallower levels first. A step that depends on another agent waits for that agent's acknowledge before the next step begins. On a wake event the block undoes the applied steps in reverse order. For C6 this means: close the power gate, wait for power-good, restore state, ungate clocks, release the pipeline. A wake that arrives part way through entry aborts the sequence, and only the steps already taken are unwound.

The clock tree, the power switch, the cache and the save memory are outside this block. Each one is reached through a request/acknowledge pair.

Top module: `core_idle_seq`

## Requirements
- R1: While reset is asserted, and after reset is released, every control output is 0 and `res_state` reads 0 (C0).
- R2: A request is accepted only when all of the following hold: the block is in C0, `idle_req` is high, `idle_depth` is 1 (C1), 2 (C3) or 3 (C6), and `wake` is low. A request with depth 0 is ignored. So is a request made while the block is not in C0, or in the same cycle as `wake`.
- R3: After an accepted request, `stall` rises in the following cycle. `clk_gate_part` rises one cycle after that, and `res_state` then reads 1.
- R4: For depth C3 or C6, `flush_req` rises the cycle after `clk_gate_part` and stays high until `flush_ack` is sampled. `clk_gate_rest` rises in the cycle after that acknowledge, `flush_req` drops, and `res_state` reads 2.
- R5: For depth C6, `save_req` rises the cycle after `clk_gate_rest` and stays high until `save_ack` is sampled. `pwr_gate_en` rises in the next cycle, `save_req` drops, and `res_state` reads 3.
- R6: `res_state` gives the deepest level whose full set of steps is in effect: 0 for C0, 1 for C1 (stall and partial gating), 2 for C3 (plus remaining gating), 3 for C6 (plus the power gate).
- R7: A wake in C6 drops `pwr_gate_en` in the next cycle. The block then waits for `pwr_good`. `restore_req` rises the cycle after `pwr_good` is sampled and stays high until `restore_ack`. `clk_gate_rest` drops the cycle after that acknowledge, then `clk_gate_part` drops, then `stall` drops.
- R8: A wake while resident in C3 drops `clk_gate_rest` in the next cycle, then `clk_gate_part`, then `stall`. A wake while resident in C1 drops `clk_gate_part` in the next cycle, then `stall`. Neither case issues a restore.
- R9: A wake during the flush wait drops `flush_req` and `clk_gate_part` together, then drops `stall`. The remaining clocks are never gated.
- R10: A wake during the save wait drops `save_req` and `clk_gate_rest` together. The power gate never opens and no restore is requested.
- R11: A wake in the cycle after acceptance, while only `stall` is applied, returns the block to C0 in the next cycle.
- R12: When `wake` and a pending acknowledge (`flush_ack` or `save_ack`) are sampled in the same cycle, the wake wins and the sequence aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Idle request strobe |
| idle_depth | input | 2 | Requested depth: 1 C1, 2 C3, 3 C6 |
| wake | input | 1 | Wake event |
| flush_ack | input | 1 | Cache flush finished |
| save_ack | input | 1 | State save finished |
| pwr_good | input | 1 | Core supply is back within limits |
| restore_ack | input | 1 | State restore finished |
| stall | output | 1 | Pipeline stall |
| clk_gate_part | output | 1 | Gate most core clocks (snoop clock stays on) |
| clk_gate_rest | output | 1 | Gate the remaining core clocks |
| flush_req | output | 1 | Cache flush request |
| save_req | output | 1 | State save request |
| pwr_gate_en | output | 1 | Open the core power gate |
| restore_req | output | 1 | State restore request |
| res_state | output | 2 | Resident level code 0..3 |

## Verification
Every depth is driven into the block, with a wake placed at each entry step in turn. The aborted runs show whether unwinding depends on the step reached and not on the requested depth. The full runs show the complete reverse order, including the waits for power-good and the restore acknowledge. Each acknowledged step is held for extra cycles before its acknowledge arrives, which shows whether the block really waits. The runs where wake and acknowledge arrive together show whether the priority between them is right. Depth 0, requests during a sleep state, and requests that coincide with wake show whether the acceptance filter is correct.

// File: rtl/cis_pkg.sv
package cis_pkg;
  localparam int LVL_W = 2;
  localparam int ST_W  = 4;

  typedef enum logic [LVL_W-1:0] {
    LVL_C0 = 2'd0,
    LVL_C1 = 2'd1,
    LVL_C3 = 2'd2,
    LVL_C6 = 2'd3
  } lvl_e;

  typedef enum logic [ST_W-1:0] {
    ST_ACT,
    ST_STALL,
    ST_C1,
    ST_FLUSH,
    ST_C3,
    ST_SAVE,
    ST_C6,
    ST_XPWR,
    ST_RESTORE,
    ST_XREST,
    ST_XPART
  } seq_state_e;

  typedef struct packed {
    logic stall;
    logic part;
    logic rest;
    logic flush;
    logic save;
    logic pg;
    logic restore;
    lvl_e res;
  } ctl_s;
endpackage

// File: rtl/cis_rst_sync.sv
module cis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/cis_depth_dec.sv
module cis_depth_dec
  import cis_pkg::*;
(
  input  logic             idle_req,
  input  logic [LVL_W-1:0] idle_depth,
  input  logic             wake,
  input  logic             in_active,
  output logic             start,
  output lvl_e             target
);
  always_comb begin
    target = lvl_e'(idle_depth);
    start  = idle_req && in_active && !wake && (target != LVL_C0);
  end
endmodule

// File: rtl/cis_fsm.sv
module cis_fsm
  import cis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  lvl_e       target,
  input  logic       wake,
  input  logic       flush_ack,
  input  logic       save_ack,
  input  logic       pwr_good,
  input  logic       restore_ack,
  output seq_state_e state
);
  seq_state_e state_q, state_d;
  lvl_e       tgt_q;
  logic       tgt_en;

  assign tgt_en = start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACT:     if (start) state_d = ST_STALL;
      ST_STALL:   state_d = wake ? ST_ACT : ST_C1;
      ST_C1: begin
        if (wake)                  state_d = ST_XPART;
        else if (tgt_q != LVL_C1)  state_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        if (wake)           state_d = ST_XPART;
        else if (flush_ack) state_d = ST_C3;
      end
      ST_C3: begin
        if (wake)                  state_d = ST_XREST;
        else if (tgt_q == LVL_C6)  state_d = ST_SAVE;
      end
      ST_SAVE: begin
        if (wake)          state_d = ST_XREST;
        else if (save_ack) state_d = ST_C6;
      end
      ST_C6:      if (wake) state_d = ST_XPWR;
      ST_XPWR:    if (pwr_good) state_d = ST_RESTORE;
      ST_RESTORE: if (restore_ack) state_d = ST_XREST;
      ST_XREST:   state_d = ST_XPART;
      ST_XPART:   state_d = ST_ACT;
      default:    state_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= LVL_C1;
    else if (tgt_en) tgt_q <= target;
  end

  assign state = state_q;
endmodule

// File: rtl/cis_out_dec.sv
module cis_out_dec
  import cis_pkg::*;
(
  input  seq_state_e state,
  output ctl_s       ctl
);
  always_comb begin
    ctl = '0;
    unique case (state)
      ST_ACT: ctl = '0;
      ST_STALL, ST_XPART: ctl.stall = 1'b1;
      ST_C1, ST_FLUSH, ST_XREST: begin
        ctl.stall = 1'b1;
        ctl.part  = 1'b1;
        ctl.res   = LVL_C1;
        ctl.flush = (state == ST_FLUSH);
      end
      ST_C3, ST_SAVE, ST_XPWR, ST_RESTORE: begin
        ctl.stall   = 1'b1;
        ctl.part    = 1'b1;
        ctl.rest    = 1'b1;
        ctl.res     = LVL_C3;
        ctl.save    = (state == ST_SAVE);
        ctl.restore = (state == ST_RESTORE);
      end
      ST_C6: begin
        ctl.stall = 1'b1;
        ctl.part  = 1'b1;
        ctl.rest  = 1'b1;
        ctl.pg    = 1'b1;
        ctl.res   = LVL_C6;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import cis_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic [LVL_W-1:0] idle_depth,
  input  logic             wake,
  input  logic             flush_ack,
  input  logic             save_ack,
  input  logic             pwr_good,
  input  logic             restore_ack,
  output logic             stall,
  output logic             clk_gate_part,
  output logic             clk_gate_rest,
  output logic             flush_req,
  output logic             save_req,
  output logic             pwr_gate_en,
  output logic             restore_req,
  output logic [LVL_W-1:0] res_state
);
  logic       rst_sync_n;
  logic       start;
  lvl_e       target;
  seq_state_e state;
  ctl_s       ctl;

  cis_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cis_depth_dec u_dec (
    .idle_req   (idle_req),
    .idle_depth (idle_depth),
    .wake       (wake),
    .in_active  (state == ST_ACT),
    .start      (start),
    .target     (target)
  );

  cis_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .target      (target),
    .wake        (wake),
    .flush_ack   (flush_ack),
    .save_ack    (save_ack),
    .pwr_good    (pwr_good),
    .restore_ack (restore_ack),
    .state       (state)
  );

  cis_out_dec u_out (
    .state (state),
    .ctl   (ctl)
  );

  assign stall         = ctl.stall;
  assign clk_gate_part = ctl.part;
  assign clk_gate_rest = ctl.rest;
  assign flush_req     = ctl.flush;
  assign save_req      = ctl.save;
  assign pwr_gate_en   = ctl.pg;
  assign restore_req   = ctl.restore;
  assign res_state     = ctl.res;
endmodule

// File: rtl/cis_checker.sv
module cis_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wake,
  input logic       flush_ack,
  input logic       save_ack,
  input logic       pwr_good,
  input logic       stall,
  input logic       clk_gate_part,
  input logic       clk_gate_rest,
  input logic       flush_req,
  input logic       save_req,
  input logic       pwr_gate_en,
  input logic       restore_req,
  input logic [1:0] res_state
);
  a_r3_part_needs_stall: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_part |-> stall);

  a_r4_rest_after_flush_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_rest) |-> ($past(flush_ack) && !$past(wake)));

  a_r4_flush_only_mid: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (clk_gate_part && !clk_gate_rest));

  a_r5_pg_after_save_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_gate_en) |-> ($past(save_ack) && !$past(wake)));

  a_r5_pg_needs_rest: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_gate_en |-> clk_gate_rest);

  a_r6_c6_code: assert property (@(posedge clk) disable iff (!rst_n)
    (res_state == 2'd3) |-> pwr_gate_en);

  a_r7_restore_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restore_req) |-> $past(pwr_good));

  a_r7_restore_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> (clk_gate_rest && !pwr_gate_en));

  a_r8_stall_released_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> !clk_gate_part);

  a_r2_one_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_req, save_req, restore_req}));

  a_r12_wake_beats_flush_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && wake) |=> !clk_gate_rest);
endmodule

bind core_idle_seq cis_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wake          (wake),
  .flush_ack     (flush_ack),
  .save_ack      (save_ack),
  .pwr_good      (pwr_good),
  .stall         (stall),
  .clk_gate_part (clk_gate_part),
  .clk_gate_rest (clk_gate_rest),
  .flush_req     (flush_req),
  .save_req      (save_req),
  .pwr_gate_en   (pwr_gate_en),
  .restore_req   (restore_req),
  .res_state     (res_state)
);

// File: tb/tb_core_idle_seq.sv
module tb_core_idle_seq;
  logic       clk;
  logic       rst_n;
  logic       idle_req;
  logic [1:0] idle_depth;
  logic       wake, flush_ack, save_ack, pwr_good, restore_ack;
  logic       stall, clk_gate_part, clk_gate_rest, flush_req, save_req;
  logic       pwr_gate_en, restore_req;
  logic [1:0] res_state;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  core_idle_seq dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_depth(idle_depth),
    .wake(wake), .flush_ack(flush_ack), .save_ack(save_ack),
    .pwr_good(pwr_good), .restore_ack(restore_ack), .stall(stall),
    .clk_gate_part(clk_gate_part), .clk_gate_rest(clk_gate_rest),
    .flush_req(flush_req), .save_req(save_req), .pwr_gate_en(pwr_gate_en),
    .restore_req(restore_req), .res_state(res_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Step codes: 0 C0, 1 stall, 2 C1, 3 flush wait, 4 C3, 5 save wait, 6 C6,
  // 7 power closing, 8 restore wait, 9 remaining ungated, 10 partial ungated
  function automatic logic [8:0] ev(int s);
    case (s)
      1, 10:  return 9'b1000000_00;
      2, 9:   return 9'b1100000_01;
      3:      return 9'b1101000_01;
      4, 7:   return 9'b1110000_10;
      5:      return 9'b1110100_10;
      6:      return 9'b1110010_11;
      8:      return 9'b1110001_10;
      default: return 9'b0000000_00;
    endcase
  endfunction

  task automatic chk(string tag, int s);
    logic [8:0] obs;
    obs = {stall, clk_gate_part, clk_gate_rest, flush_req, save_req,
           pwr_gate_en, restore_req, res_state};
    checks++;
    if (obs !== ev(s)) begin
      errs++;
      $display("FAIL %s step %0d: actual=%b expected=%b", tag, s, obs, ev(s));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic unwind(int s);
    if (s == 6) begin
      chk("R7 gate closing", 7);
      tick();
      chk("R7 waits for power good", 7);
      pwr_good = 1'b1;
      tick();
      pwr_good = 1'b0;
      chk("R7 restore request", 8);
      tick();
      chk("R7 restore held", 8);
      restore_ack = 1'b1;
      tick();
      restore_ack = 1'b0;
      chk("R7 remaining clocks on", 9);
      tick();
      chk("R7 partial clocks on", 10);
      tick();
      chk("R7 stall released", 0);
    end else if (s == 4 || s == 5) begin
      chk(s == 5 ? "R10 save abort" : "R8 leave C3", 9);
      tick();
      chk("R8 partial clocks on", 10);
      tick();
      chk("R8 back to C0", 0);
    end else if (s == 2 || s == 3) begin
      chk(s == 3 ? "R9 flush abort" : "R8 leave C1", 10);
      tick();
      chk("R9 back to C0", 0);
    end else begin
      chk("R11 stall-only abort", 0);
    end
  endtask

  // Enter depth d; wake at path index a; both=1 pairs wake with the pending ack
  task automatic run(int d, int a, bit both);
    idle_req   = 1'b1;
    idle_depth = 2'(d);
    tick();
    idle_req   = 1'b0;
    idle_depth = 2'd0;
    for (int i = 0; i < 2 * d; i++) begin
      int s = i + 1;
      chk(s <= 2 ? "R3 entry" : (s <= 4 ? "R4 entry" : "R5 entry"), s);
      if (s == 2) chk("R6 code C1", 2);
      if (i == a) begin
        wake = 1'b1;
        if (both) begin
          flush_ack = (s == 3);
          save_ack  = (s == 5);
        end
        tick();
        wake = 1'b0; flush_ack = 1'b0; save_ack = 1'b0;
        if (both && (s == 3 || s == 5)) chk("R12 wake wins", s == 3 ? 10 : 9);
        else unwind(s);
        return;
      end
      if (s == 3) begin
        tick();
        chk("R4 flush held", 3);
        flush_ack = 1'b1;
        tick();
        flush_ack = 1'b0;
      end else if (s == 5) begin
        tick();
        chk("R5 save held", 5);
        save_ack = 1'b1;
        tick();
        save_ack = 1'b0;
      end else if (s == 2 * d) begin
        tick();
        chk("R6 resident holds", s);
        tick();
      end else begin
        tick();
      end
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 6; k++) tick();
    chk("R1 idle between runs", 0);
  endtask

  initial begin
    rst_n = 1'b0; idle_req = 1'b0; idle_depth = 2'd0; wake = 1'b0;
    flush_ack = 1'b0; save_ack = 1'b0; pwr_good = 1'b0; restore_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) tick();
    chk("R1 after reset", 0);

    // R2: depth 0 ignored
    idle_req = 1'b1; idle_depth = 2'd0;
    tick();
    idle_req = 1'b0;
    chk("R2 depth 0 ignored", 0);
    tick();
    chk("R2 depth 0 ignored", 0);

    // R2: request together with wake ignored
    idle_req = 1'b1; idle_depth = 2'd3; wake = 1'b1;
    tick();
    idle_req = 1'b0; wake = 1'b0;
    chk("R2 request with wake ignored", 0);

    // Sweep every depth and every wake point
    for (int d = 1; d <= 3; d++) begin
      for (int a = 0; a < 2 * d; a++) begin
        run(d, a, 1'b0);
        drain();
        if (a == 2 || a == 4) begin
          run(d, a, 1'b1);
          drain();
        end
      end
    end

    // R2: a new request while resident in C3 is ignored
    idle_req = 1'b1; idle_depth = 2'd2;
    tick();
    idle_req = 1'b0;
    tick();
    tick();
    flush_ack = 1'b1;
    tick();
    flush_ack = 1'b0;
    chk("R4 in C3", 4);
    idle_req = 1'b1; idle_depth = 2'd3;
    tick();
    tick();
    idle_req = 1'b0;
    chk("R2 request in C3 ignored", 4);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    chk("R8 leave C3", 9);
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule